// File: doc/BRIEF.md
# MII Receive Frame Checker

This block sits on the receive side of a 4-bit media-independent interface. It watches the nibble stream and its data-valid strobe. It discards the preamble and locks onto the start-of-frame delimiter. It then pairs nibbles into bytes and forwards the frame body on a byte-wide stream marked by valid and last flags. The trailing four check bytes are held back, so downstream logic only ever sees destination address through payload.

While bytes arrive, a CRC-32 engine runs over every byte, including the received check sequence, and a counter tracks frame length. When the data-valid strobe falls, the block emits a one-cycle status pulse. The pulse carries three flags: check sequence good, frame too short, and frame ended on half a byte. Its intended use is a loopback bench, where a matching transmitter feeds this block to prove that both CRC implementations agree, and then live reception.

Top module: `mii_frame_checker`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_last`, `stat_valid` and all three status flags are low.
- R2: A frame begins with the nibble after a nibble 0x5 that is directly followed by a nibble 0xD (delimiter byte 0xD5, low nibble first) while `mii_dv` is high. Preamble nibbles produce no output. A 0xD5 byte inside the frame body is ordinary data.
- R3: Each assembled byte holds the first nibble received in bits 3:0 and the second nibble in bits 7:4.
- R4: The output stream carries every received byte except the final four, in arrival order. `out_last` is high only on the final forwarded byte.
- R5: `stat_valid` is a one-cycle pulse, raised by the second rising edge counted from, and including, the first edge that samples `mii_dv` low after frame data. `stat_fcs_ok` is high exactly when the reflected CRC-32 (polynomial 0xEDB88320, preset to all ones) over all received bytes, check bytes included, ends at the register value 0xDEBB20E3. A transmitter produces the check bytes as the inverted CRC of the preceding bytes, sent low byte first.
- R6: `stat_too_short` is high when the frame, check bytes included, holds fewer than 64 bytes. A frame of exactly 64 bytes is not short.
- R7: `stat_align_err` is high when an odd number of nibbles followed the delimiter. The unpaired nibble is dropped.
- R8: If `mii_dv` falls before a delimiter has been seen, there is no status pulse and no output byte.
- R9: `out_last` occurs in the same cycle as `stat_valid`. A frame of four bytes or fewer forwards no bytes but still reports status.
- R10: A frame carrying a transmitter-generated check sequence reports good status even when it directly follows a frame with a bad check sequence. The CRC is re-preset at every delimiter.
- R11: All three status flags are low in every cycle in which `stat_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mii_nib | input | 4 | Receive nibble |
| mii_dv | input | 1 | Receive data valid |
| out_byte | output | 8 | Forwarded frame byte |
| out_valid | output | 1 | `out_byte` holds a byte this cycle |
| out_last | output | 1 | Final forwarded byte of the frame |
| stat_valid | output | 1 | End-of-frame status pulse |
| stat_fcs_ok | output | 1 | Check sequence matched |
| stat_too_short | output | 1 | Frame below minimum length |
| stat_align_err | output | 1 | Odd nibble count after delimiter |

## Verification
The bench uses the defaults: a four-byte holdback, a 64-byte minimum and a 16-bit length counter. With these values it can drive the minimum-length boundary at 63 and 64 bytes in a few hundred cycles. It also drives frames shorter than the holdback depth, which must forward nothing. A known-good 64-byte frame with literal check bytes anchors the CRC. The bench's own CRC model produces the check bytes for every other frame, which stands in for the matching transmitter in loopback.

// File: rtl/mii_fcs_pkg.sv
package mii_fcs_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD_REM  = 32'hDEBB20E3;
    localparam logic [3:0]  NIB_PREAMBLE  = 4'h5;
    localparam logic [3:0]  NIB_SFD_HIGH  = 4'hD;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_PREAMBLE,
        RX_BODY
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    typedef struct packed {
        logic fcs_ok;
        logic too_short;
        logic align_err;
    } frame_flags_t;

    // One byte through the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  din);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ din[b])
                c = (c >> 1) ^ CRC_POLY_REFL;
            else
                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_nib_assembler.sv
module mii_nib_assembler
    import mii_fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] nib,
    input  logic       dv,
    output byte_beat_t beat,
    output logic       sof,
    output logic       eof,
    output logic       eof_odd
);

    rx_state_e  state;
    logic [3:0] prev_nib;
    logic [3:0] low_nib;
    logic       half;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            prev_nib <= '0;
            low_nib  <= '0;
            half     <= 1'b0;
            beat     <= '0;
            sof      <= 1'b0;
            eof      <= 1'b0;
            eof_odd  <= 1'b0;
        end else begin
            beat.valid <= 1'b0;
            sof        <= 1'b0;
            eof        <= 1'b0;
            eof_odd    <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (dv) begin
                        state    <= RX_PREAMBLE;
                        prev_nib <= nib;
                    end
                end
                RX_PREAMBLE: begin
                    if (!dv) begin
                        state <= RX_IDLE;
                    end else if (nib == NIB_SFD_HIGH && prev_nib == NIB_PREAMBLE) begin
                        state <= RX_BODY;
                        half  <= 1'b0;
                        sof   <= 1'b1;
                    end else begin
                        prev_nib <= nib;
                    end
                end
                RX_BODY: begin
                    if (!dv) begin
                        state   <= RX_IDLE;
                        eof     <= 1'b1;
                        eof_odd <= half;
                        half    <= 1'b0;
                    end else if (!half) begin
                        low_nib <= nib;
                        half    <= 1'b1;
                    end else begin
                        beat.valid <= 1'b1;
                        beat.data  <= {nib, low_nib};
                        half       <= 1'b0;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mii_crc_engine.sv
module mii_crc_engine
    import mii_fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       preset,
    input  byte_beat_t beat,
    output logic       crc_match
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || preset)
            crc_q <= CRC_PRESET;
        else if (beat.valid)
            crc_q <= crc32_step(crc_q, beat.data);
    end

    assign crc_match = (crc_q == CRC_GOOD_REM);

endmodule

// File: rtl/mii_byte_holdback.sv
module mii_byte_holdback
    import mii_fcs_pkg::*;
#(
    parameter int HOLD_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  byte_beat_t beat,
    input  logic       eof,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       out_last
);

    localparam int FILL_W = $clog2(HOLD_BYTES + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HOLD_BYTES);

    logic [7:0]        pipe [HOLD_BYTES];
    logic [FILL_W-1:0] fill;
    logic [7:0]        pend;
    logic              pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HOLD_BYTES; i++) pipe[i] <= '0;
            fill      <= '0;
            pend      <= '0;
            pend_v    <= 1'b0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (eof) begin
                if (pend_v) begin
                    out_byte  <= pend;
                    out_valid <= 1'b1;
                    out_last  <= 1'b1;
                end
                pend_v <= 1'b0;
                fill   <= '0;
            end else if (beat.valid) begin
                pipe[0] <= beat.data;
                for (int i = 1; i < HOLD_BYTES; i++) pipe[i] <= pipe[i-1];
                if (fill == FILL_FULL) begin
                    if (pend_v) begin
                        out_byte  <= pend;
                        out_valid <= 1'b1;
                    end
                    pend   <= pipe[HOLD_BYTES-1];
                    pend_v <= 1'b1;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mii_frame_status.sv
module mii_frame_status
    import mii_fcs_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int CNT_W   = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sof,
    input  byte_beat_t   beat,
    input  logic         eof,
    input  logic         eof_odd,
    input  logic         crc_match,
    output logic         stat_valid,
    output frame_flags_t flags
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || sof)
            len_q <= '0;
        else if (beat.valid && len_q != CNT_MAX)
            len_q <= len_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid <= 1'b0;
            flags      <= '0;
        end else begin
            stat_valid <= eof;
            if (eof) begin
                flags.fcs_ok    <= crc_match;
                flags.too_short <= (len_q < LEN_MIN);
                flags.align_err <= eof_odd;
            end else begin
                flags <= '0;
            end
        end
    end

endmodule

// File: rtl/mii_frame_checker.sv
module mii_frame_checker
    import mii_fcs_pkg::*;
#(
    parameter int HOLD_BYTES = 4,
    parameter int MIN_LEN    = 64,
    parameter int CNT_W      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mii_nib,
    input  logic       mii_dv,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       out_last,
    output logic       stat_valid,
    output logic       stat_fcs_ok,
    output logic       stat_too_short,
    output logic       stat_align_err
);

    byte_beat_t   beat;
    logic         sof;
    logic         eof;
    logic         eof_odd;
    logic         crc_match;
    frame_flags_t flags;

    mii_nib_assembler u_asm (
        .clk     (clk),
        .rst     (rst),
        .nib     (mii_nib),
        .dv      (mii_dv),
        .beat    (beat),
        .sof     (sof),
        .eof     (eof),
        .eof_odd (eof_odd)
    );

    mii_crc_engine u_crc (
        .clk       (clk),
        .rst       (rst),
        .preset    (sof),
        .beat      (beat),
        .crc_match (crc_match)
    );

    mii_byte_holdback #(.HOLD_BYTES(HOLD_BYTES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .eof       (eof),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .out_last  (out_last)
    );

    mii_frame_status #(.MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .beat       (beat),
        .eof        (eof),
        .eof_odd    (eof_odd),
        .crc_match  (crc_match),
        .stat_valid (stat_valid),
        .flags      (flags)
    );

    assign stat_fcs_ok    = flags.fcs_ok;
    assign stat_too_short = flags.too_short;
    assign stat_align_err = flags.align_err;

endmodule

// File: rtl/mii_frame_checker_sva.sv
module mii_frame_checker_sva (
    input logic clk,
    input logic rst,
    input logic mii_dv,
    input logic out_valid,
    input logic out_last,
    input logic stat_valid,
    input logic stat_fcs_ok,
    input logic stat_too_short,
    input logic stat_align_err
);

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    p_status_after_dv_low_r8: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !$past(mii_dv));

    p_last_with_status_r9: assert property (@(posedge clk) disable iff (rst)
        out_last |-> stat_valid);

    p_last_is_valid_r4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    p_flags_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !stat_valid |-> !(stat_fcs_ok || stat_too_short || stat_align_err));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !(out_valid || stat_valid));

endmodule

bind mii_frame_checker mii_frame_checker_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .mii_dv         (mii_dv),
    .out_valid      (out_valid),
    .out_last       (out_last),
    .stat_valid     (stat_valid),
    .stat_fcs_ok    (stat_fcs_ok),
    .stat_too_short (stat_too_short),
    .stat_align_err (stat_align_err)
);

// File: tb/mii_frame_checker_tb.sv
`timescale 1ns/1ps
module mii_frame_checker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mii_nib = '0;
    logic       mii_dv = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid, out_last, stat_valid;
    logic       stat_fcs_ok, stat_too_short, stat_align_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mii_frame_checker u_dut (
        .clk(clk), .rst(rst), .mii_nib(mii_nib), .mii_dv(mii_dv),
        .out_byte(out_byte), .out_valid(out_valid), .out_last(out_last),
        .stat_valid(stat_valid), .stat_fcs_ok(stat_fcs_ok),
        .stat_too_short(stat_too_short), .stat_align_err(stat_align_err)
    );

    // monitor state
    int         cyc = 0;
    logic [7:0] rx_mem [0:1023];
    int         rx_n = 0;
    int         last_pos = -1;
    int         last_sync_n = 0;
    int         stat_n = 0;
    int         st_cyc = 0;
    bit         st_ok, st_short, st_align;

    // frame under construction
    logic [7:0] fb [0:127];
    int         nb = 0;
    int         drop_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (rx_n < 1024) rx_mem[rx_n] = out_byte;
                if (out_last) begin
                    last_pos = rx_n;
                    if (stat_valid) last_sync_n++;
                end
                rx_n++;
            end
            if (stat_valid) begin
                stat_n++;
                st_ok    = stat_fcs_ok;
                st_short = stat_too_short;
                st_align = stat_align_err;
                st_cyc   = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bench_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb_bit;
                fb_bit = c[0] ^ fb[i][b];
                c = c >> 1;
                if (fb_bit) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic add_fcs(input int n);
        logic [31:0] f;
        f = bench_crc(n);
        fb[n]   = f[7:0];
        fb[n+1] = f[15:8];
        fb[n+2] = f[23:16];
        fb[n+3] = f[31:24];
        nb = n + 4;
    endtask

    task automatic fill_pattern(input int n, input int seed);
        for (int i = 0; i < n; i++) fb[i] = 8'((i * 37 + seed) ^ (i >> 2));
    endtask

    task automatic put_nib(input logic dv, input logic [3:0] n);
        @(negedge clk);
        mii_dv  = dv;
        mii_nib = n;
    endtask

    task automatic send_frame(input int pre_bytes, input bit odd);
        for (int i = 0; i < pre_bytes; i++) begin
            put_nib(1'b1, 4'h5);
            put_nib(1'b1, 4'h5);
        end
        put_nib(1'b1, 4'h5);
        put_nib(1'b1, 4'hD);
        for (int i = 0; i < nb; i++) begin
            put_nib(1'b1, fb[i][3:0]);
            put_nib(1'b1, fb[i][7:4]);
        end
        if (odd) put_nib(1'b1, 4'hA);
        @(negedge clk);
        mii_dv   = 1'b0;
        mii_nib  = 4'h0;
        drop_cyc = cyc;
        repeat (8) @(negedge clk);
    endtask

    task automatic verify_frame(input string tag, input int rx0, input int st0,
                                input int ls0, input bit e_ok, input bit e_short,
                                input bit e_align);
        int pay;
        bit same;
        pay = (nb > 4) ? nb - 4 : 0;
        chk(stat_n - st0 == 1, "R5", {tag, " status pulses"}, stat_n - st0, 1);
        chk(st_cyc == drop_cyc + 2, "R5", {tag, " status timing"}, st_cyc, drop_cyc + 2);
        chk(st_ok == e_ok, "R5", {tag, " fcs_ok"}, st_ok, e_ok);
        chk(st_short == e_short, "R6", {tag, " too_short"}, st_short, e_short);
        chk(st_align == e_align, "R7", {tag, " align_err"}, st_align, e_align);
        chk(rx_n - rx0 == pay, "R4", {tag, " forwarded count"}, rx_n - rx0, pay);
        same = 1'b1;
        for (int i = 0; i < pay && i < rx_n - rx0; i++)
            if (rx_mem[rx0 + i] !== fb[i]) same = 1'b0;
        chk(same, "R3", {tag, " byte content"}, same, 1);
        if (pay > 0) begin
            chk(last_pos == rx0 + pay - 1, "R4", {tag, " last position"},
                last_pos - rx0, pay - 1);
            chk(last_sync_n - ls0 == 1, "R9", {tag, " last with status"},
                last_sync_n - ls0, 1);
        end
    endtask

    task automatic t_reset;
        chk(!out_valid && !out_last, "R1", "stream after reset", {out_valid, out_last}, 0);
        chk(!stat_valid && !stat_fcs_ok && !stat_too_short && !stat_align_err,
            "R1", "status after reset",
            {stat_valid, stat_fcs_ok, stat_too_short, stat_align_err}, 0);
    endtask

    task automatic load_reference;
        logic [7:0] hdr [0:11];
        hdr = '{8'h00, 8'h01, 8'h80, 8'h3f, 8'h6c, 8'he6,
                8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'ha0};
        for (int i = 0; i < 64; i++) fb[i] = 8'h00;
        for (int i = 0; i < 12; i++) fb[i] = hdr[i];
        fb[60] = 8'h75; fb[61] = 8'h78; fb[62] = 8'h03; fb[63] = 8'h93;
        nb = 64;
    endtask

    task automatic t_reference;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        load_reference();
        send_frame(7, 1'b0);
        verify_frame("R5 reference", rx0, st0, ls0, 1'b1, 1'b0, 1'b0);
        chk(rx_mem[rx0 + 2] == 8'h80, "R3", "nibble order of byte 2", rx_mem[rx0 + 2], 8'h80);
    endtask

    task automatic t_flipped;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        load_reference();
        fb[20] = fb[20] ^ 8'h10;
        send_frame(7, 1'b0);
        verify_frame("R5 flipped bit", rx0, st0, ls0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_loopback_after_bad;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        fill_pattern(80, 11);
        add_fcs(80);
        send_frame(7, 1'b0);
        verify_frame("R10 loopback", rx0, st0, ls0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_len(input int total, input bit e_short, input string tag);
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        fill_pattern(total - 4, total);
        add_fcs(total - 4);
        send_frame(3, 1'b0);
        verify_frame(tag, rx0, st0, ls0, 1'b1, e_short, 1'b0);
    endtask

    task automatic t_short_preamble_sfd_in_body;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        fill_pattern(40, 3);
        fb[5] = 8'hD5; fb[6] = 8'h55; fb[7] = 8'hD5;
        add_fcs(40);
        send_frame(0, 1'b0);
        verify_frame("R2 minimal preamble, D5 in body", rx0, st0, ls0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_odd;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        fill_pattern(66, 7);
        add_fcs(66);
        send_frame(7, 1'b1);
        verify_frame("R7 odd nibble", rx0, st0, ls0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_abort;
        int rx0 = rx_n, st0 = stat_n;
        for (int i = 0; i < 6; i++) put_nib(1'b1, 4'h5);
        put_nib(1'b1, 4'hA);
        put_nib(1'b1, 4'hD);
        @(negedge clk);
        mii_dv = 1'b0;
        repeat (10) @(negedge clk);
        chk(stat_n == st0, "R8", "status without delimiter", stat_n - st0, 0);
        chk(rx_n == rx0, "R8", "bytes without delimiter", rx_n - rx0, 0);
    endtask

    task automatic t_tiny;
        int rx0 = rx_n, st0 = stat_n, ls0 = last_sync_n;
        fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
        nb = 3;
        send_frame(2, 1'b0);
        verify_frame("R9 tiny frame", rx0, st0, ls0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reference();
        t_flipped();
        t_loopback_after_bad();
        t_len(63, 1'b1, "R6 length 63");
        t_len(64, 1'b0, "R6 length 64");
        t_short_preamble_sfd_in_body();
        t_odd();
        t_abort();
        t_tiny();
        t_len(5, 1'b1, "R9 one payload byte");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule